// File: doc/BRIEF.md
# Debug trigger state sequencer

This block follows a programmed path of comparator hits and fires a trigger when the path completes. Three comparator channels deliver single-cycle match pulses. While armed, the sequencer sits in one of three working states. Each working state has its own 4-bit code that selects, per channel, whether a hit moves it to another working state, to the final step, or nowhere. Reaching the final step emits a one-cycle trigger and drops the armed flag.

Software reaches the block through a small byte-wide register port. The port has a control register that holds the arm bit and a 2-bit bank select. A banked window exposes one of the three state codes or a read-only status byte. A channel-enable register completes the port. The codes and the enables can only be changed while the sequencer is disarmed. When several hits land in the same cycle, a hit that leads to the final step wins. Otherwise the lowest-numbered channel wins.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset, bus reads at 0x26, 0x27 (in every bank) and 0x28 return 0x00, and trig_o and armed_o are 0.
- R2: Register 0x26 holds the bank select in bits [1:0] and the arm command in bit 7, and reads back as {armed, 5'b0, bank}. Writing bit 7 = 1 while disarmed arms the sequencer in State1. Writing bit 7 = 0 disarms it to idle. Writing bit 7 = 1 while armed leaves the state unchanged.
- R3: Register 0x27 is banked. Bank 00 holds the State1 code, bank 01 the State2 code and bank 10 the State3 code, each in bits [3:0] with bits [7:4] reading 0. Bank 11 is a read-only status byte {armed, 5'b0, state}, where state is 00 idle, 01 State1, 10 State2 and 11 State3.
- R4: Writes to 0x27 and 0x28 are dropped while the sequencer is armed. Writes to the status bank are always dropped.
- R5: Register 0x28 bits [2:0] enable channels 0 to 2. A hit on a disabled channel never changes the state.
- R6: In State3 the codes act as follows (ch = channel, F = final):
  - 0: ch0 to State1.
  - 1: ch1 to F, ch2 to State2.
  - 2: ch1 to State1, ch0 to F.
  - 3: ch2 to State1, ch1 to F.
  - 4: ch1 to State2.
  - 5: ch1 to F.
  - 6: ch0 to F, ch2 to State2.
  - 7: ch0 to F.
  - 0xA: ch0 to F, and ch1 or ch2 to State1.
  - 0xD: ch0 to State1, and ch1 or ch2 to F.
  - 0xE: ch2 to F, ch0 to State2.
- R7: In State1 the codes act as follows:
  - 0: ch0 to State2.
  - 1: ch1 to State2.
  - 2: ch2 to State2.
  - 3: ch0 to State3.
  - 4: ch1 to State3.
  - 5: ch0 to F.
  - 6: ch1 to F.
  - 7: ch2 to F.
  - 8: ch0 to State2, ch1 to F.
- R8: In State2 the codes act as follows:
  - 0: ch0 to State3.
  - 1: ch1 to State3.
  - 2: ch2 to State3.
  - 3: ch0 to State1.
  - 4: ch0 to F.
  - 5: ch1 to F.
  - 6: ch2 to F.
  - 7: ch1 to State1, ch2 to F.
- R9: A hit that the active code does not name has no effect. Every code not listed for a state (e.g. 8, 9, 0xB, 0xC, 0xF in State3) moves nowhere.
- R10: Among enabled hits in one cycle, any hit leading to F wins. Otherwise the lowest channel's target is taken.
- R11: A hit leading to F drives trig_o high for exactly the next cycle, and the sequencer returns to idle with armed_o low.
- R12: A write to 0x26 in the same cycle as hits takes precedence, and those hits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| match_i | input | 3 | Comparator hit pulses, one bit per channel |
| trig_o | output | 1 | One-cycle trigger on reaching final |
| armed_o | output | 1 | Sequencer armed |

## Verification
On every cycle, the assertions check the following:
- the trigger is a single-cycle pulse and coincides with disarming;
- a disarmed sequencer sits idle;
- the state holds when no enabled hit arrives;
- codes and enables stay frozen while armed;
- a final-bound hit always wins the resolver;
- a control write overrides hits.

Only the bench's scenarios can show that each code's table steers every hit pattern to the right state. They also show that reserved codes and the banked window map correctly, because the bench walks every code with every hit combination in every working state.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int NCH     = 3;
  localparam int NSTAGE  = 3;
  localparam int CODE_W  = 4;
  localparam int DATA_W  = 8;

  typedef enum logic [2:0] {TGT_NONE, TGT_S1, TGT_S2, TGT_S3, TGT_FIN} tgt_e;
  typedef enum logic [1:0] {ST_IDLE = 2'b00, ST_S1 = 2'b01, ST_S2 = 2'b10, ST_S3 = 2'b11} st_e;
endpackage

// File: rtl/dbg_seq_lut.sv
module dbg_seq_lut
  import dbg_seq_pkg::*;
#(
  parameter int STAGE = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output tgt_e [NCH-1:0]    tgt_o
);
  generate
    if (STAGE == 1) begin : g_s1
      always_comb begin
        for (int c = 0; c < NCH; c++) tgt_o[c] = TGT_NONE;
        case (code_i)
          4'h0: tgt_o[0] = TGT_S2;
          4'h1: tgt_o[1] = TGT_S2;
          4'h2: tgt_o[2] = TGT_S2;
          4'h3: tgt_o[0] = TGT_S3;
          4'h4: tgt_o[1] = TGT_S3;
          4'h5: tgt_o[0] = TGT_FIN;
          4'h6: tgt_o[1] = TGT_FIN;
          4'h7: tgt_o[2] = TGT_FIN;
          4'h8: begin tgt_o[0] = TGT_S2; tgt_o[1] = TGT_FIN; end
          default: ;
        endcase
      end
    end else if (STAGE == 2) begin : g_s2
      always_comb begin
        for (int c = 0; c < NCH; c++) tgt_o[c] = TGT_NONE;
        case (code_i)
          4'h0: tgt_o[0] = TGT_S3;
          4'h1: tgt_o[1] = TGT_S3;
          4'h2: tgt_o[2] = TGT_S3;
          4'h3: tgt_o[0] = TGT_S1;
          4'h4: tgt_o[0] = TGT_FIN;
          4'h5: tgt_o[1] = TGT_FIN;
          4'h6: tgt_o[2] = TGT_FIN;
          4'h7: begin tgt_o[1] = TGT_S1; tgt_o[2] = TGT_FIN; end
          default: ;
        endcase
      end
    end else begin : g_s3
      always_comb begin
        for (int c = 0; c < NCH; c++) tgt_o[c] = TGT_NONE;
        case (code_i)
          4'h0: tgt_o[0] = TGT_S1;
          4'h1: begin tgt_o[1] = TGT_FIN; tgt_o[2] = TGT_S2;  end
          4'h2: begin tgt_o[1] = TGT_S1;  tgt_o[0] = TGT_FIN; end
          4'h3: begin tgt_o[2] = TGT_S1;  tgt_o[1] = TGT_FIN; end
          4'h4: tgt_o[1] = TGT_S2;
          4'h5: tgt_o[1] = TGT_FIN;
          4'h6: begin tgt_o[0] = TGT_FIN; tgt_o[2] = TGT_S2;  end
          4'h7: tgt_o[0] = TGT_FIN;
          4'hA: begin tgt_o[0] = TGT_FIN; tgt_o[1] = TGT_S1;  tgt_o[2] = TGT_S1;  end
          4'hD: begin tgt_o[0] = TGT_S1;  tgt_o[1] = TGT_FIN; tgt_o[2] = TGT_FIN; end
          4'hE: begin tgt_o[2] = TGT_FIN; tgt_o[0] = TGT_S2;  end
          default: ; // reserved: no move
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/dbg_seq_prio.sv
module dbg_seq_prio
  import dbg_seq_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] hit_i,
  input  tgt_e [NCH-1:0] tgt_i,
  output tgt_e           tgt_o
);
  logic [NCH-1:0] fin_v;
  logic [NCH-1:0] mov_v;

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    assign fin_v[c] = hit_i[c] && (tgt_i[c] == TGT_FIN);
    assign mov_v[c] = hit_i[c] && (tgt_i[c] != TGT_NONE);
  end

  always_comb begin
    tgt_o = TGT_NONE;
    for (int c = NCH - 1; c >= 0; c--)
      if (mov_v[c]) tgt_o = tgt_i[c];  // lowest channel ends up last
    if (|fin_v) tgt_o = TGT_FIN;
  end

  a_r10_final_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fin_v) |-> (tgt_o == TGT_FIN));
  a_r10_low_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mov_v[0] && !(|fin_v)) |-> (tgt_o == tgt_i[0]));
  a_r9_idle_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mov_v == '0) |-> (tgt_o == TGT_NONE));
endmodule

// File: rtl/dbg_seq_regs.sv
module dbg_seq_regs
  import dbg_seq_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h26,
  parameter logic [ADDR_W-1:0] WIN_OFS  = 8'h27,
  parameter logic [ADDR_W-1:0] ENA_OFS  = 8'h28
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          armed_i,
  input  st_e                           state_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NSTAGE-1:0][CODE_W-1:0] code_o,
  output logic [NCH-1:0]                ena_o,
  output logic                          ctl_wr_o,
  output logic                          arm_req_o
);
  localparam logic [1:0] BANK_STAT = 2'b11;

  logic [1:0]                    bank_q;
  logic [NSTAGE-1:0][CODE_W-1:0] code_q;
  logic [NCH-1:0]                ena_q;
  logic                          win_wr, ena_wr;

  assign ctl_wr_o  = we_i && (addr_i == CTRL_OFS);
  assign arm_req_o = wdata_i[DATA_W-1];
  assign win_wr    = we_i && (addr_i == WIN_OFS) && !armed_i && (bank_q != BANK_STAT);
  assign ena_wr    = we_i && (addr_i == ENA_OFS) && !armed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      code_q <= '0;
      ena_q  <= '0;
    end else begin
      if (ctl_wr_o) bank_q <= wdata_i[1:0];
      if (win_wr)   code_q[bank_q] <= wdata_i[CODE_W-1:0];
      if (ena_wr)   ena_q <= wdata_i[NCH-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFS) begin
      rdata_o[DATA_W-1] = armed_i;
      rdata_o[1:0]      = bank_q;
    end else if (addr_i == WIN_OFS) begin
      if (bank_q == BANK_STAT) begin
        rdata_o[DATA_W-1] = armed_i;
        rdata_o[1:0]      = state_i;
      end else begin
        rdata_o[CODE_W-1:0] = code_q[bank_q];
      end
    end else if (addr_i == ENA_OFS) begin
      rdata_o[NCH-1:0] = ena_q;
    end
  end

  assign code_o = code_q;
  assign ena_o  = ena_q;

  a_r4_codes_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |=> $stable(code_q));
  a_r4_ena_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |=> $stable(ena_q));
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_wr_i,
  input  logic arm_req_i,
  input  logic hit_any_i,
  input  tgt_e tgt_i,
  output st_e  state_o,
  output logic armed_o,
  output logic trig_o
);
  st_e  state_q;
  logic armed_q, trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      if (ctl_wr_i) begin
        if (!arm_req_i) begin
          armed_q <= 1'b0;
          state_q <= ST_IDLE;
        end else if (!armed_q) begin
          armed_q <= 1'b1;
          state_q <= ST_S1;
        end
      end else if (armed_q) begin
        case (tgt_i)
          TGT_S1:  state_q <= ST_S1;
          TGT_S2:  state_q <= ST_S2;
          TGT_S3:  state_q <= ST_S3;
          TGT_FIN: begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
            trig_q  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign armed_o = armed_q;
  assign trig_o  = trig_q;

  a_r11_trig_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q);
  a_r11_trig_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> (!armed_q && state_q == ST_IDLE));
  a_r2_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (state_q == ST_IDLE));
  a_r5_hold_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !ctl_wr_i && !hit_any_i) |=> (state_q == $past(state_q) && !trig_q));
  a_r12_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !arm_req_i) |=> (!armed_q && !trig_q));
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h26,
  parameter logic [ADDR_W-1:0] WIN_OFS  = 8'h27,
  parameter logic [ADDR_W-1:0] ENA_OFS  = 8'h28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic [2:0]        match_i,
  output logic              trig_o,
  output logic              armed_o
);
  logic [NSTAGE-1:0][CODE_W-1:0] code;
  logic [NCH-1:0]                ena, hit;
  logic                          ctl_wr, arm_req, armed;
  st_e                           state;
  tgt_e [NCH-1:0]                tgt_all [NSTAGE];
  tgt_e [NCH-1:0]                tgt_cur;
  tgt_e                          tgt_win;

  dbg_seq_regs #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .WIN_OFS(WIN_OFS), .ENA_OFS(ENA_OFS)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .armed_i(armed), .state_i(state), .rdata_o(bus_rdata_o),
    .code_o(code), .ena_o(ena), .ctl_wr_o(ctl_wr), .arm_req_o(arm_req)
  );

  for (genvar g = 0; g < NSTAGE; g++) begin : g_lut
    dbg_seq_lut #(.STAGE(g + 1)) u_lut (.code_i(code[g]), .tgt_o(tgt_all[g]));
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) tgt_cur[c] = TGT_NONE;
    case (state)
      ST_S1:   tgt_cur = tgt_all[0];
      ST_S2:   tgt_cur = tgt_all[1];
      ST_S3:   tgt_cur = tgt_all[2];
      default: ;
    endcase
  end

  assign hit = match_i & ena;

  dbg_seq_prio u_prio (
    .clk_i, .rst_ni, .hit_i(hit), .tgt_i(tgt_cur), .tgt_o(tgt_win)
  );

  dbg_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .ctl_wr_i(ctl_wr), .arm_req_i(arm_req), .hit_any_i(|hit), .tgt_i(tgt_win),
    .state_o(state), .armed_o(armed), .trig_o(trig_o)
  );

  assign armed_o = armed;
endmodule

// File: tb/dbg_seq_top_tb.sv
`timescale 1ns/1ps
module dbg_seq_top_tb;
  localparam logic [7:0] A_CTL = 8'h26, A_WIN = 8'h27, A_ENA = 8'h28;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [7:0] bus_addr_i = '0, bus_wdata_i = '0, bus_rdata_o;
  logic [2:0] match_i = '0;
  logic       trig_o, armed_o;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  // behavioural model
  int   m_bank = 0, m_state = 0, m_ena = 0;
  int   m_code [3] = '{0, 0, 0};
  bit   m_armed = 0, m_trig = 0;

  always #2 clk_i = ~clk_i;

  dbg_seq_top u_dut (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // target per (state, code, channel): -1 none, 1..3 state, 4 final
  function automatic int tgt(int st, int code, int ch);
    case (st)
      1: case (ch)
           0: return (code == 0 || code == 8) ? 2 : code == 3 ? 3 : code == 5 ? 4 : -1;
           1: return code == 1 ? 2 : code == 4 ? 3 : (code == 6 || code == 8) ? 4 : -1;
           default: return code == 2 ? 2 : code == 7 ? 4 : -1;
         endcase
      2: case (ch)
           0: return code == 0 ? 3 : code == 3 ? 1 : code == 4 ? 4 : -1;
           1: return code == 1 ? 3 : code == 5 ? 4 : code == 7 ? 1 : -1;
           default: return code == 2 ? 3 : (code == 6 || code == 7) ? 4 : -1;
         endcase
      3: case (ch)
           0: if (code inside {2, 6, 7, 10}) return 4;
              else if (code == 0 || code == 13) return 1;
              else if (code == 14) return 2;
              else return -1;
           1: if (code inside {1, 3, 5, 13}) return 4;
              else if (code == 2 || code == 10) return 1;
              else if (code == 4) return 2;
              else return -1;
           default:
              if (code == 13 || code == 14) return 4;
              else if (code == 3 || code == 10) return 1;
              else if (code == 1 || code == 6) return 2;
              else return -1;
         endcase
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] mread(logic [7:0] a);
    if (a == A_CTL) return {m_armed, 5'b0, 2'(m_bank)};
    if (a == A_WIN) return (m_bank == 3) ? {m_armed, 5'b0, 2'(m_state)} : 8'(m_code[m_bank]);
    if (a == A_ENA) return 8'(m_ena);
    return 8'h00;
  endfunction

  function automatic string rtag(logic [7:0] a);
    if (a == A_CTL) return "R2 ctrl read";
    if (a == A_ENA) return "R5 enable read";
    if (a == A_WIN) return (m_bank == 3) ? {cur_tag, " status R3"} : "R3/R4 window read";
    return "R3 unmapped read";
  endfunction

  task automatic cyc(bit we, logic [7:0] a, logic [7:0] d, logic [2:0] m);
    bit old_armed;
    int best;
    bit fin;
    @(negedge clk_i);
    chk(trig_o === m_trig, "R11 trig_o", int'(trig_o), int'(m_trig));
    chk(armed_o === m_armed, "R2 armed_o", int'(armed_o), int'(m_armed));
    bus_we_i = we; bus_addr_i = a; bus_wdata_i = d; match_i = m;
    #1;
    chk(bus_rdata_o === mread(a), rtag(a), int'(bus_rdata_o), int'(mread(a)));
    old_armed = m_armed;
    m_trig = 0;
    if (we && a == A_CTL) begin // R12: control write beats hits
      if (!d[7]) begin m_armed = 0; m_state = 0; end
      else if (!m_armed) begin m_armed = 1; m_state = 1; end
    end else if (m_armed) begin
      best = -1; fin = 0;
      for (int ch = 0; ch < 3; ch++)
        if (m[ch] && m_ena[ch]) begin
          int t = tgt(m_state, m_code[m_state-1], ch);
          if (t == 4) fin = 1;
          else if (t > 0 && best < 0) best = t;
        end
      if (fin) begin m_state = 0; m_armed = 0; m_trig = 1; end
      else if (best > 0) m_state = best;
    end
    if (we && a == A_WIN && !old_armed && m_bank != 3) m_code[m_bank] = int'(d[3:0]);
    if (we && a == A_ENA && !old_armed) m_ena = int'(d[2:0]);
    if (we && a == A_CTL) m_bank = int'(d[1:0]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, A_WIN, 8'h00, 3'b000);
  endtask

  // reach a working state, apply a hit pattern, then read status
  task automatic walk(int stage, int code, logic [2:0] pat, string tag);
    cur_tag = tag;
    cyc(1, A_CTL, 8'h00, 3'b000);                    // disarm
    cyc(1, A_CTL, 8'(stage - 1), 3'b000);
    cyc(1, A_WIN, 8'(code), 3'b000);
    cyc(1, A_CTL, 8'h00, 3'b000);
    if (stage == 2) cyc(1, A_WIN, 8'h00, 3'b000);    // S1 code0: ch0 -> S2
    if (stage == 3) cyc(1, A_WIN, 8'h03, 3'b000);    // S1 code3: ch0 -> S3
    cyc(1, A_ENA, 8'h07, 3'b000);
    cyc(1, A_CTL, 8'h83, 3'b000);                    // arm, status bank
    if (stage > 1) cyc(0, A_WIN, 8'h00, 3'b001);
    cyc(0, A_WIN, 8'h00, pat);
    idle(2);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset values across every register and bank
    cur_tag = "R1";
    for (int b = 0; b < 4; b++) begin
      cyc(0, A_CTL, 8'h00, 3'b000);
      cyc(0, A_WIN, 8'h00, 3'b000);
      cyc(0, A_ENA, 8'h00, 3'b000);
      cyc(1, A_CTL, 8'(b + 1), 3'b000);
    end
    cyc(1, A_CTL, 8'h00, 3'b000);
    // R5: channels disabled, hits ignored
    cyc(1, A_WIN, 8'h05, 3'b000);
    cyc(1, A_CTL, 8'h83, 3'b000);
    cyc(0, A_WIN, 8'h00, 3'b111);
    idle(2);
    chk(m_state == 1 && armed_o, "R5 disabled channels hold", int'(armed_o), 1);
    // R4: locked writes while armed
    cyc(1, A_ENA, 8'h07, 3'b000);
    cyc(1, A_CTL, 8'h80, 3'b000);
    cyc(1, A_WIN, 8'h0F, 3'b000);
    cyc(0, A_WIN, 8'h00, 3'b000);
    cyc(0, A_ENA, 8'h00, 3'b000);
    // R2: rearm while armed keeps state
    cyc(1, A_CTL, 8'h83, 3'b000);
    idle(1);
    // R12: disarm write coinciding with a final-bound hit
    cyc(1, A_CTL, 8'h00, 3'b000);
    cyc(1, A_ENA, 8'h07, 3'b000);
    cyc(1, A_CTL, 8'h83, 3'b000);
    cur_tag = "R12";
    cyc(1, A_CTL, 8'h03, 3'b001);
    idle(2);
    chk(!armed_o && !trig_o, "R12 write wins", int'(armed_o), 0);
    // R7, R8, R6 with R9/R10/R11 on every code and hit pattern
    for (int s = 1; s <= 3; s++)
      for (int c = 0; c < 16; c++)
        for (int p = 1; p < 8; p++)
          walk(s, c, 3'(p), s == 1 ? "R7 R9 R10 R11" : s == 2 ? "R8 R9 R10 R11" : "R6 R9 R10 R11");
    // mixed random traffic, partial enables
    cur_tag = "R5 R10";
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 9);
      logic [7:0] a = (r < 2) ? A_CTL : (r < 4) ? A_ENA : A_WIN;
      cyc(r < 5, a, 8'($urandom), 3'($urandom));
    end
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule